// File: doc/BRIEF.md
# DMA Control and Address Sequencer

This block runs block transfers between a host-side DMA stream and on-card sample memory. Software programs a block start position, counted in 16-byte paragraphs, and a small low-address extension. It then writes a mode register whose bit 0 opens the request. The block accepts one item per clock on a valid/ready handshake. For each item it presents the on-card byte address and performs the memory write, or passes memory read data back to the host.

For 16-bit channels the linear address is folded: the two bank bits stay in place and the rest of the offset is doubled. Each item then covers two bytes. On the host-to-card path the block can flip bit 7 of each byte, which converts between signed and unsigned sample formats. When the item flagged as last is accepted, several things happen at once. The request closes. The start position moves forward by the number of whole paragraphs moved. The extension keeps the leftover byte count. If enabled, a terminal-count flag raises the interrupt line. Reading the mode register reports that flag and clears it.

Top module: `dma_seq`

## Requirements
- R1: With `wide_chan`=0, `mem_addr` = start*16 + ext[3:0] for the first item of a block. It rises by 1 after each accepted item.
- R2: With `wide_chan`=1, the first item's address is (L & 0xC0000) + 2*(L & 0x1FFF0), where L = start*16 + ext[3:0]. It rises by 2 after each accepted item.
- R3: A mode register write (`reg_sel`=0) with bit 0 set drives `xfer_ready` high from the next cycle. With mode bit 0 clear, `xfer_ready` is low.
- R4: Mode bit 1 selects the direction, 0 = host to card and 1 = card to host. On an accepted item `mem_we` is high only for host to card. For card to host, `xfer_rdata` equals `mem_rdata` unaltered: upper byte zero when `wide_chan`=0, both bytes when `wide_chan`=1.
- R5: Host to card with mode bit 7 set: bit 7 of the low data byte is inverted unless mode bit 6 is set. Otherwise the byte passes unchanged. With `wide_chan`=0 the upper byte of `mem_wdata` is zero.
- R6: Host to card with `wide_chan`=1: the upper byte has bit 7 inverted when mode bit 7 is set, independent of bit 6.
- R7: After a last item closes a block of N items, start becomes start + (N>>4), and ext becomes (N + ext) & 0xF, with upper bits zero.
- R8: Accepting the last item clears mode bit 0, so `xfer_ready` is low from the next cycle.
- R9: If mode bit 5 is set when the last item is accepted, the terminal-count flag is set and `tc_irq` goes high the next cycle. `tc_irq` never rises otherwise.
- R10: A mode read returns the stored value, with bit 2 forced to 1 when `wide_chan`=1 and bit 6 forced to 1 when the flag is pending. The read clears the flag, which drops `tc_irq`, and clears stored bits 6 and 2.
- R11: Writing the start register (`reg_sel`=1) clears bits 7:4 of the extension register (`reg_sel`=2) and keeps bits 3:0.
- R12: After reset the mode, start and extension registers read zero, `xfer_ready` is low and `tc_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_chan | input | 1 | Host channel is 16 bits wide |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 mode, 1 start, 2 extension |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| xfer_valid | input | 1 | Host offers an item |
| xfer_ready | output | 1 | Request open, item accepted when valid |
| xfer_last | input | 1 | Offered item is the terminal count |
| xfer_wdata | input | 16 | Host data toward the card |
| xfer_rdata | output | 16 | Card data toward the host |
| mem_addr | output | 20 | On-card byte address of the current item |
| mem_we | output | 1 | Card memory write enable |
| mem_wdata | output | 16 | Transformed data for card memory |
| mem_rdata | input | 16 | Card memory read data |
| tc_irq | output | 1 | Terminal-count interrupt |

## Verification
Address, write enable and data outputs are combinational from the registers, the item counter and the current inputs. The bench therefore checks them 1 ns after driving inputs at a falling edge, before the next rising edge. Register writes, counter steps, the block-end updates and the interrupt flag take effect at the first rising edge after the stimulus. They are observed from the following falling edge onward. Read data is captured at the rising edge that samples `reg_rd`, so the bench reads `reg_rdata` after that edge, and checks the side effects of the read on the next read and on `tc_irq`.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   localparam int MODE_W = 8;

   // mode register bit positions (software-visible, position is behaviour)
   localparam int MB_REQ    = 0;
   localparam int MB_DIR    = 1;
   localparam int MB_WIDE   = 2;
   localparam int MB_TCIE   = 5;
   localparam int MB_TCST   = 6;
   localparam int MB_LOKEEP = 6;
   localparam int MB_FLIP   = 7;

   localparam logic [1:0] SEL_MODE  = 2'd0;
   localparam logic [1:0] SEL_START = 2'd1;
   localparam logic [1:0] SEL_EXT   = 2'd2;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
   import dma_seq_pkg::*;
#(
   parameter int PARA_W    = 16,
   parameter int EXT_W     = 4,
   parameter int EXT_REG_W = 8,
   parameter int CNT_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wide,
   input  logic                 wr,
   input  logic                 rd,
   input  logic [1:0]           sel,
   input  logic [PARA_W-1:0]    wdata,
   input  logic                 blk_end,
   input  logic [CNT_W:0]       blk_cnt,
   output logic [MODE_W-1:0]    mode_q,
   output logic [PARA_W-1:0]    start_q,
   output logic [EXT_REG_W-1:0] ext_q,
   output logic                 tc_pend,
   output logic [PARA_W-1:0]    rdata
);
   localparam int EXT_PAD = EXT_REG_W - EXT_W;

   logic [EXT_W-1:0]     ext_sum;
   logic [EXT_REG_W-1:0] ext_next;
   logic [PARA_W-1:0]    start_next;
   logic [MODE_W-1:0]    mode_view;
   logic                 mode_rd;

   assign mode_rd    = rd && (sel == SEL_MODE);
   assign ext_sum    = blk_cnt[EXT_W-1:0] + ext_q[EXT_W-1:0];
   assign ext_next   = {{EXT_PAD{1'b0}}, ext_sum};
   assign start_next = start_q + PARA_W'(blk_cnt >> EXT_W);

   always_comb begin
      mode_view = mode_q;
      if (wide)    mode_view[MB_WIDE] = 1'b1;
      if (tc_pend) mode_view[MB_TCST] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         start_q <= '0;
         ext_q   <= '0;
         tc_pend <= 1'b0;
         rdata   <= '0;
      end else begin
         if (mode_rd) begin
            rdata             <= PARA_W'(mode_view);
            mode_q[MB_TCST]   <= 1'b0;
            mode_q[MB_WIDE]   <= 1'b0;
            tc_pend           <= 1'b0;
         end else if (rd) begin
            case (sel)
               SEL_START: rdata <= start_q;
               SEL_EXT:   rdata <= PARA_W'(ext_q);
               default:   rdata <= '0;
            endcase
         end
         // block end: close request, advance position, flag terminal count
         if (blk_end) begin
            mode_q[MB_REQ] <= 1'b0;
            start_q        <= start_next;
            ext_q          <= ext_next;
            if (mode_q[MB_TCIE]) tc_pend <= 1'b1;
         end
         // software writes take precedence over same-cycle block updates
         if (wr) begin
            case (sel)
               SEL_MODE:  mode_q <= wdata[MODE_W-1:0];
               SEL_START: begin
                  start_q <= wdata;
                  ext_q   <= {{EXT_PAD{1'b0}}, ext_q[EXT_W-1:0]};
               end
               SEL_EXT:   ext_q <= wdata[EXT_REG_W-1:0];
               default:   ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
   parameter int PARA_W   = 16,
   parameter int EXT_W    = 4,
   parameter int CNT_W    = 16,
   parameter bit HAS_WIDE = 1'b1,
   localparam int AW      = PARA_W + EXT_W
) (
   input  logic [PARA_W-1:0] start_q,
   input  logic [EXT_W-1:0]  ext_lo,
   input  logic              wide,
   input  logic [CNT_W-1:0]  cnt,
   output logic [AW-1:0]     addr
);
   localparam int BANK_W = 2;

   logic [AW-1:0] lin;
   assign lin = {start_q, {EXT_W{1'b0}}} + AW'(ext_lo);

   generate
      if (HAS_WIDE) begin : g_fold
         logic [AW-1:0] bank;
         logic [AW-1:0] mid;
         logic [AW-1:0] folded;
         assign bank   = {lin[AW-1:AW-BANK_W], {(AW-BANK_W){1'b0}}};
         assign mid    = AW'(lin[AW-BANK_W-2:EXT_W]) << (EXT_W + 1);
         assign folded = bank + mid;
         assign addr   = wide ? (folded + (AW'(cnt) << 1)) : (lin + AW'(cnt));
      end else begin : g_flat
         logic unused_wide;
         assign unused_wide = wide;
         assign addr = lin + AW'(cnt);
      end
   endgenerate
endmodule

// File: rtl/dma_seq_xform.sv
module dma_seq_xform
   import dma_seq_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int BYTE_W = DATA_W / 2
) (
   input  logic [MODE_W-1:0] mode_q,
   input  logic              wide,
   input  logic [DATA_W-1:0] host_data,
   input  logic [DATA_W-1:0] card_data,
   output logic [DATA_W-1:0] to_card,
   output logic [DATA_W-1:0] to_host
);
   logic flip_any, flip_lo, flip_hi;
   logic [BYTE_W-1:0] lo_b, hi_b;

   assign flip_any = mode_q[MB_FLIP] & ~mode_q[MB_DIR];
   assign flip_lo  = flip_any & ~mode_q[MB_LOKEEP];
   assign flip_hi  = flip_any;

   assign lo_b = host_data[BYTE_W-1:0]      ^ {flip_lo, {(BYTE_W-1){1'b0}}};
   assign hi_b = host_data[DATA_W-1:BYTE_W] ^ {flip_hi, {(BYTE_W-1){1'b0}}};

   assign to_card = wide ? {hi_b, lo_b} : {{BYTE_W{1'b0}}, lo_b};
   assign to_host = wide ? card_data : {{BYTE_W{1'b0}}, card_data[BYTE_W-1:0]};
endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_seq_pkg::*;
#(
   parameter int PARA_W    = 16,
   parameter int EXT_W     = 4,
   parameter int EXT_REG_W = 8,
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 16,
   parameter bit HAS_WIDE  = 1'b1,
   localparam int AW       = PARA_W + EXT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_chan,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_sel,
   input  logic [PARA_W-1:0] reg_wdata,
   output logic [PARA_W-1:0] reg_rdata,
   input  logic              xfer_valid,
   output logic              xfer_ready,
   input  logic              xfer_last,
   input  logic [DATA_W-1:0] xfer_wdata,
   output logic [DATA_W-1:0] xfer_rdata,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              tc_irq
);
   generate
      if (PARA_W < MODE_W)          begin : g_bad_para  $error("PARA_W must hold the mode register"); end
      if (EXT_REG_W < EXT_W)        begin : g_bad_ext   $error("EXT_REG_W must be at least EXT_W"); end
      if (AW < EXT_W + 4)           begin : g_bad_aw    $error("address too narrow for bank fold"); end
      if (DATA_W != 2 * (DATA_W/2)) begin : g_bad_data  $error("DATA_W must be two bytes wide"); end
      if (CNT_W < EXT_W)            begin : g_bad_cnt   $error("CNT_W must be at least EXT_W"); end
   endgenerate

   logic [MODE_W-1:0]    mode_q;
   logic [PARA_W-1:0]    start_q;
   logic [EXT_REG_W-1:0] ext_q;
   logic                 tc_pend;
   logic [CNT_W-1:0]     cnt_q;
   logic                 wide_eff;
   logic                 accept;
   logic                 blk_end;
   logic                 mode_wr;
   logic [CNT_W:0]       blk_cnt;

   assign wide_eff   = HAS_WIDE ? wide_chan : 1'b0;
   assign xfer_ready = mode_q[MB_REQ];
   assign accept     = xfer_valid & xfer_ready;
   assign blk_end    = accept & xfer_last;
   assign mode_wr    = reg_wr && (reg_sel == SEL_MODE);
   assign blk_cnt    = {1'b0, cnt_q} + 1'b1;
   assign mem_we     = accept & ~mode_q[MB_DIR];
   assign tc_irq     = tc_pend;

   // item counter within the current block
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (mode_wr || blk_end) cnt_q <= '0;
      else if (accept)           cnt_q <= cnt_q + 1'b1;
   end

   dma_seq_regs #(
      .PARA_W(PARA_W), .EXT_W(EXT_W), .EXT_REG_W(EXT_REG_W), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wide(wide_eff),
      .wr(reg_wr), .rd(reg_rd), .sel(reg_sel), .wdata(reg_wdata),
      .blk_end(blk_end), .blk_cnt(blk_cnt),
      .mode_q(mode_q), .start_q(start_q), .ext_q(ext_q),
      .tc_pend(tc_pend), .rdata(reg_rdata)
   );

   dma_seq_addr #(
      .PARA_W(PARA_W), .EXT_W(EXT_W), .CNT_W(CNT_W), .HAS_WIDE(HAS_WIDE)
   ) u_addr (
      .start_q(start_q), .ext_lo(ext_q[EXT_W-1:0]), .wide(wide_eff),
      .cnt(cnt_q), .addr(mem_addr)
   );

   dma_seq_xform #(.DATA_W(DATA_W)) u_xform (
      .mode_q(mode_q), .wide(wide_eff),
      .host_data(xfer_wdata), .card_data(mem_rdata),
      .to_card(mem_wdata), .to_host(xfer_rdata)
   );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
   parameter int AW = 20,
   parameter int PW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wide_chan,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [1:0]    reg_sel,
   input logic [PW-1:0] reg_wdata,
   input logic [PW-1:0] reg_rdata,
   input logic          xfer_valid,
   input logic          xfer_ready,
   input logic          xfer_last,
   input logic [AW-1:0] mem_addr,
   input logic          tc_irq,
   input logic [7:0]    mode_q
);
   logic acc, mode_wr, mode_rd;
   assign acc     = xfer_valid && xfer_ready;
   assign mode_wr = reg_wr && (reg_sel == 2'd0);
   assign mode_rd = reg_rd && (reg_sel == 2'd0);

   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !xfer_last && !wide_chan && !reg_wr) |=>
      (wide_chan || mem_addr == AW'($past(mem_addr) + AW'(1))));

   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !xfer_last && wide_chan && !reg_wr) |=>
      (!wide_chan || mem_addr == AW'($past(mem_addr) + AW'(2))));

   p_req_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && reg_wdata[0]) |=> xfer_ready);

   p_tc_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && xfer_last && !mode_wr) |=> !xfer_ready);

   p_tc_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && xfer_last && mode_q[5]) |=> tc_irq);

   p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_irq) |-> $past(acc && xfer_last));

   p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && tc_irq && !(acc && xfer_last)) |=> (!tc_irq && reg_rdata[6]));

   p_wide_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && wide_chan) |=> reg_rdata[2]);
endmodule

bind dma_seq dma_seq_chk #(.AW(AW), .PW(PARA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wide_chan(wide_chan),
   .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_last(xfer_last),
   .mem_addr(mem_addr), .tc_irq(tc_irq), .mode_q(mode_q)
);

// File: tb/dma_seq_bench.sv
module dma_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_chan = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        xfer_valid = 1'b0, xfer_ready, xfer_last = 1'b0;
   logic [15:0] xfer_wdata = '0, xfer_rdata;
   logic [19:0] mem_addr;
   logic        mem_we;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        tc_irq;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   dma_seq u_dma_seq (
      .clk(clk), .rst_n(rst_n), .wide_chan(wide_chan),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_last(xfer_last),
      .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .tc_irq(tc_irq)
   );

   // {mode, wide, input data, expected data}
   localparam int NV = 9;
   localparam logic [40:0] VEC [NV] = '{
      {8'h01, 1'b0, 16'h1234, 16'h0034},
      {8'h81, 1'b0, 16'h1234, 16'h00B4},
      {8'h81, 1'b0, 16'h00FF, 16'h007F},
      {8'hC1, 1'b0, 16'h00FF, 16'h00FF},
      {8'h81, 1'b1, 16'h8080, 16'h0000},
      {8'hC1, 1'b1, 16'h8080, 16'h0080},
      {8'h01, 1'b1, 16'hA5C3, 16'hA5C3},
      {8'h83, 1'b0, 16'h12F0, 16'h00F0},
      {8'h83, 1'b1, 16'hF00F, 16'hF00F}
   };

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] s, output logic [15:0] d);
      @(negedge clk); reg_sel = s; reg_rd = 1'b1;
      @(negedge clk); reg_rd = 1'b0;
      #1 d = reg_rdata;
   endtask

   task automatic item(input logic [15:0] d, input logic last, input logic [19:0] exp_addr, input string tag);
      @(negedge clk); xfer_wdata = d; xfer_valid = 1'b1; xfer_last = last;
      #1 chk(mem_addr == exp_addr, tag, 32'(mem_addr), 32'(exp_addr));
      @(negedge clk); xfer_valid = 1'b0; xfer_last = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R12 reset state
      chk(xfer_ready == 1'b0, "R12 ready", 32'(xfer_ready), 0);
      chk(tc_irq == 1'b0, "R12 irq", 32'(tc_irq), 0);
      rreg(2'd0, rd); chk(rd == 16'h0000, "R12 mode", 32'(rd), 0);
      rreg(2'd1, rd); chk(rd == 16'h0000, "R12 start", 32'(rd), 0);

      // table: data transform and direction (R4 R5 R6)
      for (int i = 0; i < NV; i++) begin
         logic [40:0] v;
         v = VEC[i];
         @(negedge clk); wide_chan = v[32];
         wreg(2'd0, {8'h00, v[40:33]});
         @(negedge clk);
         xfer_wdata = v[31:16]; mem_rdata = v[31:16]; xfer_valid = 1'b1;
         #1;
         if (v[34]) begin
            chk(xfer_rdata == v[15:0], "R4 card-to-host data", 32'(xfer_rdata), 32'(v[15:0]));
            chk(mem_we == 1'b0, "R4 no write card-to-host", 32'(mem_we), 0);
         end else begin
            chk(mem_wdata == v[15:0], v[32] ? "R6 wide transform" : "R5 byte transform",
                32'(mem_wdata), 32'(v[15:0]));
            chk(mem_we == 1'b1, "R4 write host-to-card", 32'(mem_we), 1);
         end
         xfer_valid = 1'b0;
      end

      // R1 R7 R8: byte channel, 3-item block
      @(negedge clk); wide_chan = 1'b0;
      wreg(2'd1, 16'h0123);
      wreg(2'd2, 16'h0005);
      wreg(2'd0, 16'h0001);
      #1 chk(xfer_ready == 1'b1, "R3 request open", 32'(xfer_ready), 1);
      item(16'h0011, 1'b0, 20'h01235, "R1 item0 addr");
      item(16'h0022, 1'b0, 20'h01236, "R1 item1 addr");
      item(16'h0033, 1'b1, 20'h01237, "R1 item2 addr");
      #1 chk(xfer_ready == 1'b0, "R8 request closed", 32'(xfer_ready), 0);
      chk(tc_irq == 1'b0, "R9 no irq when disabled", 32'(tc_irq), 0);
      rreg(2'd1, rd); chk(rd == 16'h0123, "R7 start after 3", 32'(rd), 32'h0123);
      rreg(2'd2, rd); chk(rd == 16'h0008, "R7 ext after 3", 32'(rd), 32'h0008);

      // R7 R9 R10: 20-item block with terminal-count interrupt
      wreg(2'd1, 16'h0010);
      wreg(2'd2, 16'h000E);
      wreg(2'd0, 16'h0021);
      for (int k = 0; k < 20; k++)
         item(16'h0000, (k == 19), 20'h0010E + 20'(k), "R1 long block addr");
      #1 chk(tc_irq == 1'b1, "R9 irq raised", 32'(tc_irq), 1);
      rreg(2'd0, rd); chk(rd == 16'h0060, "R10 mode read with flag", 32'(rd), 32'h0060);
      chk(tc_irq == 1'b0, "R10 irq cleared by read", 32'(tc_irq), 0);
      rreg(2'd0, rd); chk(rd == 16'h0020, "R10 flag gone", 32'(rd), 32'h0020);
      rreg(2'd1, rd); chk(rd == 16'h0011, "R7 start after 20", 32'(rd), 32'h0011);
      rreg(2'd2, rd); chk(rd == 16'h0002, "R7 ext after 20", 32'(rd), 32'h0002);

      // R2: 16-bit channel fold
      @(negedge clk); wide_chan = 1'b1;
      wreg(2'd1, 16'h5ABC);
      wreg(2'd2, 16'h0003);
      wreg(2'd0, 16'h0001);
      item(16'h1111, 1'b0, 20'h75780, "R2 wide item0 addr");
      item(16'h2222, 1'b1, 20'h75782, "R2 wide item1 addr");
      rreg(2'd0, rd); chk(rd == 16'h0004, "R10 wide flag", 32'(rd), 32'h0004);
      rreg(2'd2, rd); chk(rd == 16'h0005, "R7 ext after wide block", 32'(rd), 32'h0005);

      // R11: start write trims extension
      @(negedge clk); wide_chan = 1'b0;
      wreg(2'd2, 16'h00A7);
      rreg(2'd2, rd); chk(rd == 16'h00A7, "R11 ext full", 32'(rd), 32'h00A7);
      wreg(2'd1, 16'h0200);
      rreg(2'd2, rd); chk(rd == 16'h0007, "R11 ext trimmed", 32'(rd), 32'h0007);

      // R10: stored bits 6 and 2 cleared by a read
      wreg(2'd0, 16'h0044);
      rreg(2'd0, rd); chk(rd == 16'h0044, "R10 first read", 32'(rd), 32'h0044);
      rreg(2'd0, rd); chk(rd == 16'h0000, "R10 bits cleared", 32'(rd), 0);

      // R3: no request, no ready, then open
      #1 chk(xfer_ready == 1'b0, "R3 ready low", 32'(xfer_ready), 0);
      wreg(2'd0, 16'h0001);
      #1 chk(xfer_ready == 1'b1, "R3 ready high", 32'(xfer_ready), 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule